// File: doc/BRIEF.md
# Bus Hold Request Arbiter

This block decides when an external bus master may take the local bus away from the processor. The request input is active high and level sensitive, and it is sampled on the rising clock edge. The block raises the acknowledge only at a safe boundary. A safe boundary is the end of a bus cycle that is not followed by more cycles of the same DMA transfer or the same locked sequence. While the acknowledge is high, a float enable tells the pad logic to tri-state the address/data and control outputs.

A pending memory-refresh request outranks the hold request. If both are pending at a safe boundary, the refresh cycle runs first and the grant moves to the next safe boundary. The acknowledge is held for as long as the request stays high. Once the request drops, the acknowledge falls at the next edge. A short resume gap then keeps the block from granting again until the processor has restarted its bus activity.

The bus cycle sequencer, the DMA engine and the refresh timer are not part of this block. They report their state through the strobe and flag inputs.

Top module: `holdBusArbiter`

## Requirements
- R1: While the reset input `rstN` is low, `holdAck` and `floatEn` are both low. After reset they stay low until a grant happens.
- R2: A grant needs `holdReq` sampled high on two edges in a row: the edge before the grant edge and the grant edge itself. If the request first appears on the edge of a safe boundary, no grant is made at that boundary.
- R3: `holdAck` rises only on the edge after a grant edge. A grant edge is an edge where `cycleDone` = 1, `dmaActive` = 0, `lockActive` = 0 and `refreshReq` = 0. An edge with `cycleDone` = 0 never grants.
- R4: When `cycleDone` = 1 arrives with `dmaActive` = 1, the transfer continues and no grant is made. With back-to-back 4-clock bus cycles, a request that arrives as a 4-cycle transfer starts is granted exactly 16 clocks after its first sampling edge.
- R5: When `cycleDone` = 1 arrives with `lockActive` = 1, the locked sequence continues and no grant is made. The grant comes at the end of the last cycle of the sequence.
- R6: If `refreshReq` = 1 at an otherwise safe boundary, no grant is made there. The grant is made at the next safe boundary where `refreshReq` = 0.
- R7: Once granted, `holdAck` stays high on every edge at which `holdReq` is high, whatever the other inputs do.
- R8: When `holdReq` is sampled low while `holdAck` is high, `holdAck` is low after that same edge.
- R9: `floatEn` equals `holdAck` in every cycle.
- R10: After a release edge, no grant is made on the next `RESUME_CLKS` edges. `RESUME_CLKS` is at least 1. The first edge after that gap may grant again.
- R11: If the request drops before a safe boundary is reached, no grant is made.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| holdReq | input | 1 | Bus hold request from the external master, level sensitive |
| refreshReq | input | 1 | A memory refresh cycle is pending |
| dmaActive | input | 1 | Qualifies `cycleDone`: more cycles of the current DMA transfer follow |
| lockActive | input | 1 | Qualifies `cycleDone`: more cycles of the current locked sequence follow |
| cycleDone | input | 1 | One-clock strobe on the last clock of each bus cycle |
| holdAck | output | 1 | Hold acknowledge to the external master |
| floatEn | output | 1 | Tri-state enable for the bus outputs |

## Verification
Faults in this block show up at the ports as timing errors on `holdAck`. A controller stuck in its release state shows up at the next safe boundary, because the grant never comes. A stale request sample gives a grant one edge too early, at a boundary where the request had only just appeared. Losing track of a DMA or locked sequence gives a grant at an inner cycle end, several bus cycles too early. A wrong gap count shows up as a grant on the first edge after release.

// File: rtl/holdArbPkg.sv
package holdArbPkg;

  // Control state of the arbiter
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,  // processor owns the bus
    ST_HOLD   = 2'd1,  // external master owns the bus
    ST_RESUME = 2'd2   // processor restarting, no new grant
  } arbState_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic setAck;   // raise acknowledge and float enable
    logic clrAck;   // drop acknowledge and float enable
    logic loadGap;  // start the resume gap counter
    logic decGap;   // count down the resume gap
  } arbStrobe_t;

endpackage

// File: rtl/holdArbDatapath.sv
module holdArbDatapath
  import holdArbPkg::*;
#(
  parameter int RESUME_CLKS = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       holdReq,
  input  arbStrobe_t strb,
  output logic       holdSeen,
  output logic       gapLast,
  output logic       ackOut,
  output logic       floatOut
);

  localparam int GAP_W = (RESUME_CLKS < 2) ? 1 : $clog2(RESUME_CLKS + 1);
  localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(RESUME_CLKS);
  localparam logic [GAP_W-1:0] GAP_ONE  = GAP_W'(1);

  logic             seenQ;
  logic             ackQ;
  logic             floatQ;
  logic [GAP_W-1:0] gapCnt;

  // Request sample from the previous edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seenQ <= 1'b0;
    else       seenQ <= holdReq;
  end

  // Acknowledge register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            ackQ <= 1'b0;
    else if (strb.setAck) ackQ <= 1'b1;
    else if (strb.clrAck) ackQ <= 1'b0;
  end

  // Float enable has its own flop, so the pads get their own driver
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            floatQ <= 1'b0;
    else if (strb.setAck) floatQ <= 1'b1;
    else if (strb.clrAck) floatQ <= 1'b0;
  end

  // Resume gap counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             gapCnt <= '0;
    else if (strb.loadGap) gapCnt <= GAP_LOAD;
    else if (strb.decGap)  gapCnt <= gapCnt - GAP_ONE;
  end

  assign holdSeen = seenQ;
  assign gapLast  = (gapCnt <= GAP_ONE);
  assign ackOut   = ackQ;
  assign floatOut = floatQ;

endmodule

// File: rtl/holdArbControl.sv
module holdArbControl
  import holdArbPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       holdReq,
  input  logic       holdSeen,
  input  logic       refreshReq,
  input  logic       dmaActive,
  input  logic       lockActive,
  input  logic       cycleDone,
  input  logic       gapLast,
  output arbStrobe_t strb
);

  arbState_t state;
  arbState_t stateNext;
  logic      safePoint;
  logic      reqSteady;

  // End of a bus cycle with no continuation pending
  assign safePoint = cycleDone && !dmaActive && !lockActive;
  // Request seen on this edge and on the edge before
  assign reqSteady = holdReq && holdSeen;

  always_comb begin
    stateNext = state;
    strb      = '0;
    unique case (state)
      ST_RUN: begin
        if (safePoint && reqSteady && !refreshReq) begin
          strb.setAck = 1'b1;
          stateNext   = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (!holdReq) begin
          strb.clrAck  = 1'b1;
          strb.loadGap = 1'b1;
          stateNext    = ST_RESUME;
        end
      end
      ST_RESUME: begin
        if (gapLast) stateNext   = ST_RUN;
        else         strb.decGap = 1'b1;
      end
      default: stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNext;
  end

endmodule

// File: rtl/holdBusArbiter.sv
module holdBusArbiter
  import holdArbPkg::*;
#(
  parameter int RESUME_CLKS = 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic holdReq,
  input  logic refreshReq,
  input  logic dmaActive,
  input  logic lockActive,
  input  logic cycleDone,
  output logic holdAck,
  output logic floatEn
);

  arbStrobe_t strb;
  logic       holdSeen;
  logic       gapLast;

  holdArbControl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .holdReq    (holdReq),
    .holdSeen   (holdSeen),
    .refreshReq (refreshReq),
    .dmaActive  (dmaActive),
    .lockActive (lockActive),
    .cycleDone  (cycleDone),
    .gapLast    (gapLast),
    .strb       (strb)
  );

  holdArbDatapath #(.RESUME_CLKS(RESUME_CLKS)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .holdReq  (holdReq),
    .strb     (strb),
    .holdSeen (holdSeen),
    .gapLast  (gapLast),
    .ackOut   (holdAck),
    .floatOut (floatEn)
  );

endmodule

// File: rtl/holdArbChecker.sv
module holdArbChecker (
  input logic clk,
  input logic rstN,
  input logic holdReq,
  input logic refreshReq,
  input logic dmaActive,
  input logic lockActive,
  input logic cycleDone,
  input logic holdAck,
  input logic floatEn
);

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rstN |-> (!holdAck && !floatEn));

  // R2
  req_two_samples_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdAck) |-> ($past(holdReq) && $past(holdReq, 2)));

  // R3
  safe_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdAck) |-> $past(cycleDone && !dmaActive && !lockActive));

  // R6
  refresh_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdAck) |-> !$past(refreshReq));

  // R7
  ack_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (holdAck && holdReq) |=> holdAck);

  // R8
  ack_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (holdAck && !holdReq) |=> !holdAck);

  // R9
  float_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    floatEn == holdAck);

  // R10
  resume_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(holdAck) |=> !holdAck);

endmodule

bind holdBusArbiter holdArbChecker chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .holdReq    (holdReq),
  .refreshReq (refreshReq),
  .dmaActive  (dmaActive),
  .lockActive (lockActive),
  .cycleDone  (cycleDone),
  .holdAck    (holdAck),
  .floatEn    (floatEn)
);

// File: tb/holdBusArbiter_tb.sv
module holdBusArbiter_tb_top;

  localparam int GAP = 2;
  localparam int CLKS_PER_CYCLE = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic holdReq = 1'b0;
  logic refreshReq = 1'b0;
  logic dmaActive = 1'b0;
  logic lockActive = 1'b0;
  logic cycleDone = 1'b0;
  logic holdAck;
  logic floatEn;

  int nRun = 0;
  int nFail = 0;

  always #10 clk = ~clk;  // 50 MHz

  holdBusArbiter #(.RESUME_CLKS(GAP)) dut_i (
    .clk(clk), .rstN(rstN), .holdReq(holdReq), .refreshReq(refreshReq),
    .dmaActive(dmaActive), .lockActive(lockActive), .cycleDone(cycleDone),
    .holdAck(holdAck), .floatEn(floatEn)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive the inputs, let one edge pass, then settle away from the edge
  task automatic tick(input logic h, input logic r, input logic d, input logic l, input logic c);
    holdReq = h; refreshReq = r; dmaActive = d; lockActive = l; cycleDone = c;
    @(posedge clk);
    #2;
  endtask

  task automatic doReset();
    holdReq = 0; refreshReq = 0; dmaActive = 0; lockActive = 0; cycleDone = 0;
    rstN = 0;
    repeat (2) @(posedge clk);
    #2;
    check("R1 ack in reset", holdAck, 1'b0);
    check("R1 float in reset", floatEn, 1'b0);
    rstN = 1;
  endtask

  // The request arrives as a sequence of nCyc bus cycles starts. An extra
  // refresh cycle may follow. Expected grant clock: (cycles run) * 4.
  task automatic runSeq(input string tag, input int nCyc, input bit useDma,
                        input bit useLock, input bit refreshLast);
    int cnt = 0;
    int firstGrant = 0;
    int total = nCyc + (refreshLast ? 1 : 0);
    int expGrant = total * CLKS_PER_CYCLE;
    doReset();
    for (int cyc = 0; cyc < total; cyc++) begin
      for (int ph = 0; ph < CLKS_PER_CYCLE; ph++) begin
        logic more;
        more = (cyc < nCyc - 1);
        tick(1'b1, refreshLast && (cyc == nCyc - 1), useDma && more, useLock && more,
             ph == CLKS_PER_CYCLE - 1);
        cnt++;
        if (holdAck && firstGrant == 0) firstGrant = cnt;
      end
    end
    nRun++;
    if (firstGrant != expGrant) begin
      nFail++;
      $display("FAIL %s: actual grant clock %0d expected %0d", tag, firstGrant, expGrant);
    end
    tick(1'b0, 0, 0, 0, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin : main
    string tag;
    doReset();
    tick(0, 0, 0, 0, 1);
    check("R1 no grant without request", holdAck, 1'b0);

    // Sweep every combination of continuation and refresh at a boundary
    for (int c = 0; c < 8; c++) begin
      logic r, d, l;
      r = c[0]; d = c[1]; l = c[2];
      tag = (c == 0) ? "R3" : (d ? "R4" : (l ? "R5" : "R6"));
      doReset();
      tick(1, 0, 0, 0, 0);
      tick(1, 0, 0, 0, 0);
      tick(1, r, d, l, 1);
      check({tag, " boundary grant"}, holdAck, c == 0);
      check("R9 float follows ack", floatEn, c == 0);
      if (c != 0) begin
        tick(1, 0, 0, 0, 0);
        check("R3 no grant mid cycle", holdAck, 1'b0);
        tick(1, 0, 0, 0, 1);
        check({tag, " grant at next safe boundary"}, holdAck, 1'b1);
      end
      for (int k = 0; k < 8; k++) begin
        tick(1, k[0], k[1], k[2], k[0] ^ k[1]);
        check("R7 ack held", holdAck, 1'b1);
        check("R9 float held", floatEn, 1'b1);
      end
      tick(0, 0, 0, 0, 1);
      check("R8 release", holdAck, 1'b0);
      check("R9 float release", floatEn, 1'b0);
      for (int g = 0; g < GAP; g++) begin
        tick(1, 0, 0, 0, 1);
        check("R10 no grant in gap", holdAck, 1'b0);
      end
      tick(1, 0, 0, 0, 1);
      check("R10 grant after gap", holdAck, 1'b1);
      tick(0, 0, 0, 0, 0);
    end

    // Request first seen at the boundary edge itself
    doReset();
    tick(1, 0, 0, 0, 1);
    check("R2 fresh request not granted", holdAck, 1'b0);
    tick(1, 0, 0, 0, 1);
    check("R2 granted after one sample", holdAck, 1'b1);

    // Request withdrawn before a boundary
    doReset();
    tick(1, 0, 0, 0, 0);
    tick(0, 0, 0, 0, 1);
    check("R11 withdrawn request", holdAck, 1'b0);
    tick(0, 0, 0, 0, 1);
    check("R11 still no grant", holdAck, 1'b0);

    // Latency over multi-cycle sequences
    runSeq("R4 dma 4 cycles", 4, 1, 0, 0);
    runSeq("R5 lock 3 cycles", 3, 0, 1, 0);
    runSeq("R6 dma then refresh", 4, 1, 0, 1);
    runSeq("R5 lock 2 cycles then refresh", 2, 0, 1, 1);

    // Reset during a grant
    doReset();
    tick(1, 0, 0, 0, 0);
    tick(1, 0, 0, 0, 1);
    check("R3 grant before reset", holdAck, 1'b1);
    doReset();
    tick(1, 0, 0, 0, 0);
    check("R1 no ack after reset", holdAck, 1'b0);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule